// File: doc/BRIEF.md
# SDRAM Write Command Sequencer

The sequencer takes one write request at a time and turns it into command cycles for an SDRAM device. The command cycles go out on a 14-bit multiplexed address bus, a bank-select bus and three active-low strobes: row strobe, column strobe and write enable. Each request carries a byte address, a byte count, a data word and byte-lane enables. The block keeps a record of the row that is open in each bank. When the target row is already open, the block goes straight to the column write. When it is not, the block closes the old row if one is open, activates the new row, and waits the programmed precharge and activate-to-column delays. It issues one burst after another, and each burst advances the address, until the byte count is used up or a preempt input cuts the transfer short.

Check bits are always generated, and ECC mode changes how partial writes are handled. With ECC mode on, a request whose byte enables do not cover the whole bus word is turned into a read-modify-write. The block reads the aligned word, merges in the new bytes, regenerates the check bits and writes the whole word back. The bus-width mode sets the bus word to 8 bytes or 4 bytes, the burst step to 32 or 16 bytes, and the address mapping.

Top module: `sdram_wr_seq`

## Requirements
- R1: A request whose target row is already open in its bank gets its column write in the cycle right after the lookup cycle, which is the cycle after acceptance. No precharge and no activate are issued.
- R2: When a different row is open in the target bank, a precharge is issued in the cycle after the lookup, with bank on `ba_o` and `ma_o` zero. The activate follows exactly `t_rp_i` cycles later, with `t_rp_i` at least 2.
- R3: An activate drives the row on `ma_o` and the bank on `ba_o`. The column command follows exactly `t_rcd_i` cycles later, with `t_rcd_i` at least 2.
- R4: The strobe triple {ras_no, cas_no, we_no} is 011 for activate, 100 for write, 101 for read, 010 for precharge and 111 for no-op. It stays 111 in every other cycle.
- R5: The word address is the byte address shifted right by 3 in wide mode (`wide_i`=1) and by 2 in narrow mode. Its bits [9:0] are the column, [11:10] the bank and [25:12] the row. After each burst the byte address grows by 32 in wide mode or 16 in narrow mode, and the next burst goes through the lookup again.
- R6: `req_ready_o` is high only when the block is idle. It goes low from the cycle after acceptance. It comes back in the cycle after the last burst or the write-back. A request with a zero byte count ends after its lookup cycle and issues no command.
- R7: If `preempt_i` is high in a lookup cycle, the request ends there. No further command is issued and ready returns in the next cycle.
- R8: With ECC mode on and `req_be_i` not covering every active lane (lanes 7..0 in wide mode, 3..0 in narrow mode), the block issues a read at the aligned word. It samples `rdata_i` exactly `t_cl_i` cycles after the read, with `t_cl_i` at least 1. In the next cycle it writes back the merged word, taking enabled lanes from the request and the others from the read, with all active lanes in `wmask_o`.
- R9: `ecc_o` is a SECDED Hamming code over the written word. Data bits fill the non-power-of-two codeword positions from 3 upward. Check bit i is the XOR of the data bits whose position has bit i set (i<7 wide, i<6 narrow). The next check bit is the parity of all data and the lower check bits. Bit 7 is zero in narrow mode.
- R10: When the target bank has no open row, the activate is issued in the cycle after the lookup, with no precharge.
- R11: During reset, ready is high, the strobes are no-op, and every bank is marked closed.
- R12: With ECC mode off, a partial request is written directly, with `wmask_o` equal to the active lanes of `req_be_i`. Narrow mode drives `wdata_o[63:32]` as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Block idle, request taken |
| req_addr_i | input | 32 | Byte address |
| req_bytes_i | input | 16 | Byte count |
| req_data_i | input | 64 | Write data word |
| req_be_i | input | 8 | Byte-lane enables |
| wide_i | input | 1 | 1: 64-bit bus, 0: 32-bit bus |
| ecc_en_i | input | 1 | ECC mode, partial writes become read-modify-write |
| preempt_i | input | 1 | End the request at the next lookup |
| t_rp_i | input | 4 | Precharge-to-activate delay |
| t_rcd_i | input | 4 | Activate-to-column delay |
| t_cl_i | input | 4 | Read latency |
| rdata_i | input | 64 | Read data from the device |
| ras_no | output | 1 | Row strobe |
| cas_no | output | 1 | Column strobe |
| we_no | output | 1 | Write enable |
| ma_o | output | 14 | Multiplexed address |
| ba_o | output | 2 | Bank select |
| wdata_o | output | 64 | Write data |
| ecc_o | output | 8 | Check bits |
| wmask_o | output | 8 | Lanes written |

## Verification
Two functions can fall on the same lookup cycle: preemption, and the row-miss handling that would start a precharge. This happens when a multi-burst request runs past the last column into a bank that holds a different open row. The bench starts such a transfer, raises `preempt_i` for exactly that lookup cycle, and expects no precharge and an immediate return of ready. It then repeats the transfer without preemption and expects the precharge, the activate and the third burst at the computed cycles. The bench reference model derives every expected command, address and ready level from the requirements and compares them on every clock.

// File: rtl/sdram_wr_pkg.sv
package sdram_wr_pkg;
  // {ras_n, cas_n, we_n}
  typedef enum logic [2:0] {
    CMD_NOP = 3'b111,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_PRE = 3'b010
  } cmd_e;

  typedef enum logic [3:0] {
    S_IDLE, S_LOOK, S_PRE, S_RP, S_ACT, S_RCD, S_WR, S_RD, S_CL, S_WB
  } st_e;
endpackage

// File: rtl/sdram_ecc_gen.sv
module sdram_ecc_gen #(
  parameter int DW = 64,
  parameter int CB = 8
) (
  input  logic [DW-1:0] data_i,
  output logic [CB-1:0] chk_o
);
  always_comb begin
    int p;
    chk_o = '0;
    p = 3;
    for (int j = 0; j < DW; j++) begin
      if ((p & (p - 1)) == 0) p = p + 1;
      for (int i = 0; i < CB - 1; i++)
        if (p[i]) chk_o[i] = chk_o[i] ^ data_i[j];
      p = p + 1;
    end
    chk_o[CB-1] = (^data_i) ^ (^chk_o[CB-2:0]);
  end
endmodule

// File: rtl/sdram_open_rows.sv
module sdram_open_rows #(
  parameter int NB = 4,
  parameter int BW = 2,
  parameter int RW = 14
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [BW-1:0] bank_i,
  input  logic [RW-1:0] row_i,
  input  logic          clr_i,
  input  logic          set_i,
  output logic          open_o,
  output logic          hit_o
);
  logic [NB-1:0] vld_q;
  logic [RW-1:0] row_q [NB];

  for (genvar g = 0; g < NB; g++) begin : g_bank
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q[g] <= 1'b0;
        row_q[g] <= '0;
      end else if (clr_i && bank_i == BW'(g)) begin
        vld_q[g] <= 1'b0;
      end else if (set_i && bank_i == BW'(g)) begin
        vld_q[g] <= 1'b1;
        row_q[g] <= row_i;
      end
    end
  end

  assign open_o = vld_q[bank_i];
  assign hit_o  = open_o && (row_q[bank_i] == row_i);

  // R2
  set_clr_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) !(set_i && clr_i));
  // R10
  set_opens_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) set_i |=> open_o || $changed(bank_i));
endmodule

// File: rtl/sdram_wr_seq.sv
module sdram_wr_seq
  import sdram_wr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  parameter int COL_W  = 10,
  parameter int BANK_W = 2,
  parameter int ROW_W  = 14,
  parameter int MA_W   = 14,
  parameter int TW     = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [CNT_W-1:0]  req_bytes_i,
  input  logic [63:0]       req_data_i,
  input  logic [7:0]        req_be_i,
  input  logic              wide_i,
  input  logic              ecc_en_i,
  input  logic              preempt_i,
  input  logic [TW-1:0]     t_rp_i,
  input  logic [TW-1:0]     t_rcd_i,
  input  logic [TW-1:0]     t_cl_i,
  input  logic [63:0]       rdata_i,
  output logic              ras_no,
  output logic              cas_no,
  output logic              we_no,
  output logic [MA_W-1:0]   ma_o,
  output logic [BANK_W-1:0] ba_o,
  output logic [63:0]       wdata_o,
  output logic [7:0]        ecc_o,
  output logic [7:0]        wmask_o
);
  localparam int NB = 1 << BANK_W;

  st_e               st_q;
  cmd_e              cmd;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  bytes_q;
  logic [63:0]       data_q, merged_q;
  logic [7:0]        be_q;
  logic              wide_q, ecc_q;
  logic [TW-1:0]     cnt_q;

  logic [1:0]        wsh;
  logic [COL_W-1:0]  col;
  logic [BANK_W-1:0] bank;
  logic [ROW_W-1:0]  row;
  logic [7:0]        lanes;
  logic [CNT_W-1:0]  step;
  logic              rmw, row_open, row_hit;
  logic [63:0]       wsel;
  logic [7:0]        e64;
  logic [6:0]        e32;

  assign wsh   = wide_q ? 2'd3 : 2'd2;
  assign col   = COL_W'(addr_q >> wsh);
  assign bank  = BANK_W'(addr_q >> (32'(wsh) + COL_W));
  assign row   = ROW_W'(addr_q >> (32'(wsh) + COL_W + BANK_W));
  assign lanes = wide_q ? 8'hFF : 8'h0F;
  assign step  = wide_q ? CNT_W'(32) : CNT_W'(16);
  assign rmw   = ecc_q && ((be_q & lanes) != lanes);

  sdram_open_rows #(.NB(NB), .BW(BANK_W), .RW(ROW_W)) u_rows (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .bank_i (bank),
    .row_i  (row),
    .clr_i  (st_q == S_PRE),
    .set_i  (st_q == S_ACT),
    .open_o (row_open),
    .hit_o  (row_hit)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= S_IDLE;
      addr_q   <= '0;
      bytes_q  <= '0;
      data_q   <= '0;
      merged_q <= '0;
      be_q     <= '0;
      wide_q   <= 1'b0;
      ecc_q    <= 1'b0;
      cnt_q    <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (req_valid_i) begin
          addr_q  <= req_addr_i;
          bytes_q <= req_bytes_i;
          data_q  <= req_data_i;
          be_q    <= req_be_i;
          wide_q  <= wide_i;
          ecc_q   <= ecc_en_i;
          st_q    <= S_LOOK;
        end
        S_LOOK: begin
          if (preempt_i || bytes_q == '0) st_q <= S_IDLE;
          else if (row_hit)               st_q <= rmw ? S_RD : S_WR;
          else if (row_open)              st_q <= S_PRE;
          else                            st_q <= S_ACT;
        end
        S_PRE: begin
          cnt_q <= t_rp_i - TW'(2);
          st_q  <= S_RP;
        end
        S_RP: begin
          if (cnt_q == '0) st_q <= S_ACT;
          else             cnt_q <= cnt_q - TW'(1);
        end
        S_ACT: begin
          cnt_q <= t_rcd_i - TW'(2);
          st_q  <= S_RCD;
        end
        S_RCD: begin
          if (cnt_q == '0) st_q <= rmw ? S_RD : S_WR;
          else             cnt_q <= cnt_q - TW'(1);
        end
        S_WR: begin
          if (bytes_q <= step) st_q <= S_IDLE;
          else begin
            bytes_q <= bytes_q - step;
            addr_q  <= addr_q + ADDR_W'(step);
            st_q    <= S_LOOK;
          end
        end
        S_RD: begin
          cnt_q <= t_cl_i - TW'(1);
          st_q  <= S_CL;
        end
        S_CL: begin
          if (cnt_q == '0) begin
            for (int b = 0; b < 8; b++)
              merged_q[b*8 +: 8] <= be_q[b] ? data_q[b*8 +: 8] : rdata_i[b*8 +: 8];
            st_q <= S_WB;
          end else cnt_q <= cnt_q - TW'(1);
        end
        S_WB:    st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (st_q)
      S_PRE:       cmd = CMD_PRE;
      S_ACT:       cmd = CMD_ACT;
      S_WR, S_WB:  cmd = CMD_WR;
      S_RD:        cmd = CMD_RD;
      default:     cmd = CMD_NOP;
    endcase
  end

  assign {ras_no, cas_no, we_no} = cmd;
  assign req_ready_o = (st_q == S_IDLE);

  always_comb begin
    ma_o = '0;
    if (cmd == CMD_ACT) ma_o = MA_W'(row);
    else if (cmd == CMD_WR || cmd == CMD_RD) ma_o = MA_W'(col);
  end
  assign ba_o = (cmd == CMD_NOP) ? '0 : bank;

  always_comb begin
    wsel    = '0;
    wmask_o = '0;
    if (st_q == S_WR) begin
      wsel    = data_q;
      wmask_o = be_q & lanes;
    end else if (st_q == S_WB) begin
      wsel    = merged_q;
      wmask_o = lanes;
    end
  end
  assign wdata_o = wsel & {{32{wide_q}}, 32'hFFFF_FFFF};

  sdram_ecc_gen #(.DW(64), .CB(8)) u_ecc64 (.data_i(wdata_o),        .chk_o(e64));
  sdram_ecc_gen #(.DW(32), .CB(7)) u_ecc32 (.data_i(wdata_o[31:0]),  .chk_o(e32));
  assign ecc_o = wide_q ? e64 : {1'b0, e32};

  // R2
  pre_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd == CMD_PRE |=> cmd == CMD_NOP);
  // R3
  act_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd == CMD_ACT |=> cmd == CMD_NOP);
  // R8
  rd_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd == CMD_RD |=> cmd == CMD_NOP);
  // R6
  busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cmd != CMD_NOP |-> !req_ready_o);
  // R1
  wr_open_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) st_q == S_WR |-> row_hit);
endmodule

// File: tb/sdram_wr_seq_bench.sv
module sdram_wr_seq_bench;
  localparam logic [2:0] K_NOP = 3'b111, K_ACT = 3'b011, K_WR = 3'b100,
                         K_RD  = 3'b101, K_PRE = 3'b010;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_valid_i = 1'b0, req_ready_o;
  logic [31:0] req_addr_i = '0;
  logic [15:0] req_bytes_i = '0;
  logic [63:0] req_data_i = '0, rdata_i = '0, wdata_o;
  logic [7:0]  req_be_i = '0, ecc_o, wmask_o;
  logic wide_i = 1'b1, ecc_en_i = 1'b0, preempt_i = 1'b0;
  logic [3:0] t_rp_i = 4'd3, t_rcd_i = 4'd2, t_cl_i = 4'd3;
  logic ras_no, cas_no, we_no;
  logic [13:0] ma_o;
  logic [1:0]  ba_o;

  always #2.5 clk = ~clk;

  sdram_wr_seq u_sdram_wr_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
    .req_addr_i(req_addr_i), .req_bytes_i(req_bytes_i), .req_data_i(req_data_i),
    .req_be_i(req_be_i), .wide_i(wide_i), .ecc_en_i(ecc_en_i), .preempt_i(preempt_i),
    .t_rp_i(t_rp_i), .t_rcd_i(t_rcd_i), .t_cl_i(t_cl_i), .rdata_i(rdata_i),
    .ras_no(ras_no), .cas_no(cas_no), .we_no(we_no), .ma_o(ma_o), .ba_o(ba_o),
    .wdata_o(wdata_o), .ecc_o(ecc_o), .wmask_o(wmask_o)
  );

  typedef struct {
    logic [2:0] cmd; logic [13:0] ma; logic [1:0] ba;
    logic [63:0] wd; logic [7:0] ecc; logic [7:0] mk; string tag;
  } ev_t;

  ev_t evq [int];
  int  cyc = 0, total = 0, bad = 0;
  int  busy_a = -1, busy_d = -1, pre_cycle = -1, rd_cycle = -1;
  logic [63:0] rd_pat = 64'h0123_4567_89AB_CDEF;
  bit          ov [4];
  logic [13:0] orow [4];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(bit ok, string tag, string what, logic [63:0] act, logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s cycle=%0d act=%h exp=%h", tag, what, cyc, act, exp);
    end
  endtask

  function automatic logic [7:0] ref_ecc(logic [63:0] d, bit wide);
    int nd = wide ? 64 : 32, nc = wide ? 7 : 6, pos = 1, k = 0;
    logic [7:0] c = '0;
    logic par = 1'b0;
    while (k < nd) begin
      if ((pos & (pos - 1)) != 0) begin
        for (int i = 0; i < nc; i++) if ((pos >> i) & 1) c[i] = c[i] ^ d[k];
        k++;
      end
      pos++;
    end
    for (int i = 0; i < nd; i++) par = par ^ d[i];
    for (int i = 0; i < nc; i++) par = par ^ c[i];
    c[nc] = par;
    return c;
  endfunction

  function automatic logic [31:0] mk_addr(bit wide, int rw, int bk, int col);
    logic [31:0] w = (32'(rw) << 12) | (32'(bk) << 10) | 32'(col);
    return wide ? (w << 3) : (w << 2);
  endfunction

  task automatic put(int c, logic [2:0] cmd, logic [13:0] ma, logic [1:0] ba,
                     logic [63:0] wd, logic [7:0] ecc, logic [7:0] mk, string tag);
    ev_t e;
    e.cmd = cmd; e.ma = ma; e.ba = ba; e.wd = wd; e.ecc = ecc; e.mk = mk; e.tag = tag;
    evq[c] = e;
  endtask

  // behavioural reference: builds expected commands per absolute cycle
  task automatic plan(int a0, logic [31:0] addr, int bytes, logic [63:0] d, logic [7:0] be,
                      bit wide, bit ecc, int pre_look);
    int t = a0, b = bytes, look = 0, c;
    int step = wide ? 32 : 16;
    logic [31:0] ad = addr, wa;
    logic [7:0] lanes = wide ? 8'hFF : 8'h0F;
    logic [63:0] wm = wide ? '1 : 64'h0000_0000_FFFF_FFFF;
    logic [63:0] mg;
    bit rmw = ecc && ((be & lanes) != lanes);
    int col, bk, rw;
    string tg;
    busy_a = a0; pre_cycle = -1; rd_cycle = -1;
    forever begin
      if (look == pre_look) begin pre_cycle = t; busy_d = t + 1; return; end
      if (b == 0) begin busy_d = t + 1; return; end
      wa  = wide ? (ad >> 3) : (ad >> 2);
      col = int'(wa[9:0]); bk = int'(wa[11:10]); rw = int'(wa[25:12]);
      c = t + 1;
      tg = (look == 0) ? "R1" : "R5";
      if (!(ov[bk] && orow[bk] == 14'(rw))) begin
        if (ov[bk]) begin
          put(c, K_PRE, 14'd0, 2'(bk), 0, 0, 0, "R2");
          ov[bk] = 0; c += int'(t_rp_i);
          put(c, K_ACT, 14'(rw), 2'(bk), 0, 0, 0, "R2");
        end else put(c, K_ACT, 14'(rw), 2'(bk), 0, 0, 0, "R10");
        ov[bk] = 1; orow[bk] = 14'(rw); c += int'(t_rcd_i); tg = "R3";
      end
      if (rmw) begin
        put(c, K_RD, 14'(col), 2'(bk), 0, 0, 0, "R8");
        rd_cycle = c + int'(t_cl_i);
        for (int i = 0; i < 8; i++) mg[i*8 +: 8] = be[i] ? d[i*8 +: 8] : rd_pat[i*8 +: 8];
        mg = mg & wm;
        put(rd_cycle + 1, K_WR, 14'(col), 2'(bk), mg, ref_ecc(mg, wide), lanes, "R8");
        busy_d = rd_cycle + 2;
        return;
      end
      if (!ecc && (be & lanes) != lanes) tg = "R12";
      put(c, K_WR, 14'(col), 2'(bk), d & wm, ref_ecc(d & wm, wide), be & lanes, tg);
      if (b <= step) begin busy_d = c + 1; return; end
      b -= step; ad += 32'(step); t = c + 1; look++;
    end
  endtask

  task automatic send(logic [31:0] addr, int bytes, logic [63:0] d, logic [7:0] be,
                      bit wide, bit ecc, int pre_look);
    @(negedge clk);
    plan(cyc + 1, addr, bytes, d, be, wide, ecc, pre_look);
    req_valid_i = 1'b1; req_addr_i = addr; req_bytes_i = 16'(bytes);
    req_data_i = d; req_be_i = be; wide_i = wide; ecc_en_i = ecc;
    @(negedge clk);
    req_valid_i = 1'b0;
    while (cyc < busy_d + 1) @(negedge clk);
  endtask

  // compare and drive away from the active edge
  always @(negedge clk) begin
    ev_t e;
    logic [2:0] act;
    bool_ready: begin end
    act = {ras_no, cas_no, we_no};
    rdata_i   = (cyc == rd_cycle) ? rd_pat : ~rd_pat;
    preempt_i = (cyc == pre_cycle);
    if (!rst_ni) begin
      check(req_ready_o === 1'b1, "R11", "ready in reset", 64'(req_ready_o), 64'd1);
      check(act === K_NOP, "R11", "cmd in reset", 64'(act), 64'(K_NOP));
    end else begin
      if (evq.exists(cyc)) e = evq[cyc];
      else begin
        e.cmd = K_NOP; e.ma = 0; e.ba = 0; e.wd = 0; e.ecc = 0; e.mk = 0;
        e.tag = (pre_cycle >= 0 && cyc > pre_cycle && cyc <= busy_d + 1) ? "R7" : "R4";
      end
      check(act === e.cmd, e.tag, "cmd", 64'(act), 64'(e.cmd));
      if (e.cmd != K_NOP) begin
        check(ma_o === e.ma, e.tag, "ma", 64'(ma_o), 64'(e.ma));
        check(ba_o === e.ba, e.tag, "ba", 64'(ba_o), 64'(e.ba));
      end
      if (e.cmd == K_WR) begin
        check(wdata_o === e.wd, e.tag, "wdata", wdata_o, e.wd);
        check(wmask_o === e.mk, e.tag, "wmask", 64'(wmask_o), 64'(e.mk));
        check(ecc_o === e.ecc, "R9", "ecc", 64'(ecc_o), 64'(e.ecc));
      end
      check(req_ready_o === !(cyc >= busy_a && cyc < busy_d),
            (pre_cycle >= 0 && cyc == pre_cycle + 1) ? "R7" : "R6", "ready",
            64'(req_ready_o), 64'(!(cyc >= busy_a && cyc < busy_d)));
    end
  end

  always @(posedge clk) begin
    if (cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog cycle=%0d act=running exp=finished", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) begin ov[i] = 0; orow[i] = '0; end
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    // R10 empty bank, then R1 hit on second burst, R5 wide step
    send(mk_addr(1, 5, 0, 0), 64, 64'hA5A5_0000_1111_2222, 8'hFF, 1, 0, -1);
    // R1 row hit
    send(mk_addr(1, 5, 0, 8), 32, 64'h1234_5678_9ABC_DEF0, 8'hFF, 1, 0, -1);
    // R2 miss with open row
    send(mk_addr(1, 9, 0, 16), 32, 64'hFEDC_BA98_7654_3210, 8'hFF, 1, 0, -1);
    // R5 narrow mode, three 16-byte bursts
    send(mk_addr(0, 3, 2, 4), 48, 64'hCAFE_F00D_5555_AAAA, 8'hFF, 0, 0, -1);
    // R7 preempt in the lookup that would precharge bank 0
    send(mk_addr(1, 7, 3, 1016), 96, 64'h0F0F_0F0F_F0F0_F0F0, 8'hFF, 1, 0, 2);
    // same crossing without preempt: R2 precharge on the third burst
    send(mk_addr(1, 7, 3, 1016), 96, 64'h1357_9BDF_2468_ACE0, 8'hFF, 1, 0, -1);
    // R7 preempt at first lookup
    send(mk_addr(1, 7, 3, 0), 32, 64'h1, 8'hFF, 1, 0, 0);
    // R8 read-modify-write, wide, hit and miss
    send(mk_addr(1, 7, 3, 40), 8, 64'h1122_3344_5566_7788, 8'h0F, 1, 1, -1);
    send(mk_addr(1, 2, 1, 12), 8, 64'h99AA_BBCC_DDEE_FF00, 8'hA5, 1, 1, -1);
    // R8 narrow read-modify-write
    send(mk_addr(0, 3, 2, 100), 4, 64'h0000_0000_DEAD_BEEF, 8'h03, 0, 1, -1);
    // R12 partial without ECC
    send(mk_addr(1, 2, 1, 20), 8, 64'h7777_8888_9999_AAAA, 8'h3C, 1, 0, -1);
    // R9 full write with ECC on
    send(mk_addr(1, 2, 1, 24), 32, 64'hFFFF_0000_FFFF_0000, 8'hFF, 1, 1, -1);
    // R6 zero-byte request
    send(mk_addr(1, 2, 1, 0), 0, 64'h0, 8'hFF, 1, 0, -1);
    // other timings: R2 R3 R8
    @(negedge clk); t_rp_i = 4'd5; t_rcd_i = 4'd4; t_cl_i = 4'd1; rd_pat = 64'hA1B2_C3D4_E5F6_0718;
    send(mk_addr(1, 11, 1, 32), 8, 64'h0102_0304_0506_0708, 8'hF0, 1, 1, -1);
    send(mk_addr(0, 6, 3, 8), 32, 64'h0000_0000_2468_1357, 8'hFF, 0, 1, -1);
    repeat (3) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule